// File: doc/BRIEF.md
# Dual-Lane Serial Flash Read Shift Engine

This block is the slave-side read datapath of a serial flash interface. A separate front end decodes the command byte and then pulses `cmd_go` with a read kind. From then on the engine takes in the 24-bit start address on one lane or on two. It waits out the dummy clocks that the kind requires. Then it streams bytes from a byte-wide memory read port, on SIO1 alone or on SIO1 and SIO0 together. It drives the output enable of each pin, so both pins stay inputs until the first data bit goes out. It also moves the read pointer forward one byte at a time and wraps it at the top of the memory space.

The engine runs on a fast system clock. The serial clock, chip select and data lines are assumed to be synchronous to this clock already, and each serial clock half period is assumed to last at least two system clocks. Input bits are taken on detected rising serial clock edges, and output bits change on the system clock after a detected falling edge. SPI mode 0 and mode 3 work alike. The memory read port must return `mem_rdata` for the current `mem_addr` within one serial clock half period.

Top module: `sio_read_engine`

## Requirements
- R1: After a synchronous active-low reset, `sio_oe` is 2'b00 and `sio_out` is 2'b00.
- R2: Read kind 0 (command 03h) takes 24 address bits, MSB first, one per rising SCK edge on `sio_in[0]`, with no dummy clocks. Data goes out MSB first on `sio_out[1]`. The first bit appears after the falling edge that ends the last address clock.
- R3: Read kind 1 (command 0Bh) behaves as kind 0, except that 8 dummy clocks follow the address before the first data bit.
- R4: Read kind 2 (command 3Bh) takes the address and 8 dummy clocks on `sio_in[0]`. It returns each byte in four clocks, with bits 7,5,3,1 on `sio_out[1]` and bits 6,4,2,0 on `sio_out[0]`, highest pair first.
- R5: Read kind 3 (command BBh) takes the address two bits per rising edge in 12 clocks, with the odd bit on `sio_in[1]` and the even bit on `sio_in[0]`, A23/A22 first. Then come 4 dummy clocks whose values have no effect. Data is returned as in R4.
- R6: Bytes come from consecutive addresses while chip select stays low. The pointer keeps only the low MEM_AW address bits, so the higher address bits are ignored, and it wraps from all ones to zero.
- R7: `sio_oe` is 2'b00 during the address and dummy phases. From the first data falling edge onward it is 2'b10 for kinds 0 and 1 and 2'b11 for kinds 2 and 3. It only rises on a falling SCK edge.
- R8: Chip select going high at any point ends the command. On the next system clock `sio_oe` and `sio_out` are 2'b00, and a new command then starts from a clean state.
- R9: The phase bit counter is cleared when chip select falls, whether SCK idles low (mode 0) or high (mode 3). An aborted command therefore does not shift the next one.
- R10: `sio_out` changes only on the system clock after a falling SCK edge, or after chip select goes high. It holds while SCK is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock, synchronous to clk |
| cs_n | input | 1 | Chip select, active low |
| sio_in | input | 2 | Input values of SIO1 (bit 1) and SIO0 (bit 0) |
| cmd_go | input | 1 | One-cycle start pulse from the command decoder |
| cmd_kind | input | 2 | Read kind: 0 = 03h, 1 = 0Bh, 2 = 3Bh, 3 = BBh |
| mem_rdata | input | 8 | Byte at mem_addr from the memory array |
| mem_addr | output | MEM_AW | Memory read address |
| sio_out | output | 2 | Output values for SIO1 (bit 1) and SIO0 (bit 0) |
| sio_oe | output | 2 | Output enables for SIO1 (bit 1) and SIO0 (bit 0) |

## Verification
The bench builds the engine with ADDR_W = 24, DUMMY_W = 8 and MEM_AW = 12. This keeps the full 24-bit serial address and the real dummy lengths while shrinking the memory to 4 KiB. The wrap from 0xFFF to 0x000 is then reachable within a few bytes, and start addresses with high bits set show that those bits are ignored. Every read kind runs in both SPI modes. The bench also aborts one command in the address phase and another in the data phase, and probes the output between the rising and the falling SCK edge.

// File: rtl/sio_rd_pkg.sv
`timescale 1ns/1ps
// Shared types for the dual-lane read engine.
// Assumes: read kinds are encoded by the upstream command decoder as listed.
package sio_rd_pkg;

    typedef enum logic [1:0] {
        RD_PLAIN = 2'd0,   // single address, single data, no dummy
        RD_FAST  = 2'd1,   // single address, dummy, single data
        RD_DOUT  = 2'd2,   // single address, dummy, dual data
        RD_DIO   = 2'd3    // dual address, dual dummy, dual data
    } rd_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ADDR  = 2'd1,
        PH_DUMMY = 2'd2,
        PH_DATA  = 2'd3
    } rd_phase_e;

    // Address and dummy are taken two bits per clock
    function automatic logic kind_dual_in(rd_kind_e k);
        return (k == RD_DIO);
    endfunction

    // Data is returned two bits per clock
    function automatic logic kind_dual_out(rd_kind_e k);
        return (k == RD_DOUT) || (k == RD_DIO);
    endfunction

    // A dummy phase follows the address
    function automatic logic kind_has_dummy(rd_kind_e k);
        return (k != RD_PLAIN);
    endfunction

endpackage

// File: rtl/sio_rd_edge.sv
`timescale 1ns/1ps
// Edge detector for a group of slow synchronous level signals.
// Assumes: inputs are already synchronous to clk; RST_VAL gives each
// channel's history value after reset so no false edge is seen.
module sio_rd_edge #(
    parameter int          N       = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    logic [N-1:0] hist_q;

    for (genvar i = 0; i < N; i++) begin : g_ch
        // Keep the previous sample of channel i
        always_ff @(posedge clk) begin
            if (!rst_n) hist_q[i] <= RST_VAL[i];
            else        hist_q[i] <= lvl[i];
        end
        assign rise[i] = lvl[i] & ~hist_q[i];
        assign fall[i] = ~lvl[i] & hist_q[i];
    end

endmodule

// File: rtl/sio_rd_seq.sv
`timescale 1ns/1ps
// Phase sequencer: counts address, dummy and data clocks and issues
// shift, load and step strobes to the datapath.
// Assumes: cmd_go arrives while chip select is low, between SCK edges.
module sio_rd_seq
    import sio_rd_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int DUMMY_W = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cs_n,
    input  logic      cs_rise,
    input  logic      cs_fall,
    input  logic      sck_rise,
    input  logic      sck_fall,
    input  logic      cmd_go,
    input  rd_kind_e  cmd_kind,
    output rd_phase_e phase,
    output logic      dual_in,
    output logic      dual_out,
    output logic      addr_shift,
    output logic      data_load,
    output logic      data_shift
);

    localparam int CNT_W = $clog2(ADDR_W);
    localparam logic [CNT_W-1:0] ADDR_LAST_1 = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST_2 = CNT_W'(ADDR_W / 2 - 1);
    localparam logic [CNT_W-1:0] DUM_LAST_1  = CNT_W'(DUMMY_W - 1);
    localparam logic [CNT_W-1:0] DUM_LAST_2  = CNT_W'(DUMMY_W / 2 - 1);
    localparam logic [CNT_W-1:0] BYTE_LAST_1 = CNT_W'(7);
    localparam logic [CNT_W-1:0] BYTE_LAST_2 = CNT_W'(3);

    rd_phase_e        phase_q;
    rd_kind_e         kind_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] addr_last;
    logic [CNT_W-1:0] dum_last;
    logic [CNT_W-1:0] byte_last;

    // Per-kind clock counts of each phase
    always_comb begin
        addr_last = kind_dual_in(kind_q)  ? ADDR_LAST_2 : ADDR_LAST_1;
        dum_last  = kind_dual_in(kind_q)  ? DUM_LAST_2  : DUM_LAST_1;
        byte_last = kind_dual_out(kind_q) ? BYTE_LAST_2 : BYTE_LAST_1;
    end

    // Phase register and shared bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            kind_q  <= RD_PLAIN;
            cnt_q   <= '0;
        end else if (cs_rise) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else if (cs_fall) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (cmd_go && !cs_n) begin
                        phase_q <= PH_ADDR;
                        kind_q  <= cmd_kind;
                        cnt_q   <= '0;
                    end
                end
                PH_ADDR: begin
                    if (sck_rise) begin
                        if (cnt_q == addr_last) begin
                            cnt_q   <= '0;
                            phase_q <= kind_has_dummy(kind_q) ? PH_DUMMY : PH_DATA;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                PH_DUMMY: begin
                    if (sck_rise) begin
                        if (cnt_q == dum_last) begin
                            cnt_q   <= '0;
                            phase_q <= PH_DATA;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                PH_DATA: begin
                    if (sck_fall) begin
                        cnt_q <= (cnt_q == byte_last) ? '0 : cnt_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Strobes to the address and output datapaths
    always_comb begin
        phase      = phase_q;
        dual_in    = kind_dual_in(kind_q);
        dual_out   = kind_dual_out(kind_q);
        addr_shift = (phase_q == PH_ADDR) && sck_rise && !cs_n;
        data_load  = (phase_q == PH_DATA) && sck_fall && !cs_n && (cnt_q == '0);
        data_shift = (phase_q == PH_DATA) && sck_fall && !cs_n && (cnt_q != '0);
    end

endmodule

// File: rtl/sio_rd_addr.sv
`timescale 1ns/1ps
// Address register: assembles the serial address and steps the read
// pointer inside a MEM_AW-bit space that wraps to zero.
// Assumes: MEM_AW <= ADDR_W; higher address bits are kept but unused.
module sio_rd_addr #(
    parameter int ADDR_W = 24,
    parameter int MEM_AW = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              dual_in,
    input  logic [1:0]        sio_in,
    input  logic              step,
    output logic [MEM_AW-1:0] mem_addr
);

    localparam logic [ADDR_W-1:0] LO_MASK = ADDR_W'((64'd1 << MEM_AW) - 64'd1);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_inc;

    // Pointer step confined to the low MEM_AW bits
    always_comb begin
        addr_inc = (addr_q & ~LO_MASK) | ((addr_q + 1'b1) & LO_MASK);
    end

    // Shift in address bits, then step once per loaded byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (shift_en) begin
            if (dual_in) addr_q <= {addr_q[ADDR_W-3:0], sio_in[1], sio_in[0]};
            else         addr_q <= {addr_q[ADDR_W-2:0], sio_in[0]};
        end else if (step) begin
            addr_q <= addr_inc;
        end
    end

    assign mem_addr = addr_q[MEM_AW-1:0];

endmodule

// File: rtl/sio_rd_tx.sv
`timescale 1ns/1ps
// Output shifter: loads a byte at the first falling edge of each byte,
// shifts one or two bits per falling edge and drives the pin enables.
// Assumes: rdata is valid for the current pointer when load is strobed.
module sio_rd_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       load,
    input  logic       shift,
    input  logic       dual,
    input  logic [7:0] rdata,
    output logic [1:0] sio_out,
    output logic [1:0] sio_oe
);

    logic [7:0] sh_q;
    logic [1:0] out_q;
    logic [1:0] oe_q;

    // Byte shifter and pin drive
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            sh_q  <= '0;
            out_q <= '0;
            oe_q  <= '0;
        end else if (load) begin
            if (dual) begin
                out_q <= rdata[7:6];
                sh_q  <= {rdata[5:0], 2'b00};
                oe_q  <= 2'b11;
            end else begin
                out_q <= {rdata[7], 1'b0};
                sh_q  <= {rdata[6:0], 1'b0};
                oe_q  <= 2'b10;
            end
        end else if (shift) begin
            if (dual) begin
                out_q <= sh_q[7:6];
                sh_q  <= {sh_q[5:0], 2'b00};
            end else begin
                out_q <= {sh_q[7], 1'b0};
                sh_q  <= {sh_q[6:0], 1'b0};
            end
        end
    end

    assign sio_out = out_q;
    assign sio_oe  = oe_q;

endmodule

// File: rtl/sio_read_engine.sv
`timescale 1ns/1ps
// Dual-lane serial flash read engine, top level.
// Takes the address after the decoded command, waits the dummy clocks,
// then streams memory bytes on one or two lanes with per-pin enables.
// Assumes: sck, cs_n and sio_in are synchronous to clk; an SCK half
// period lasts at least two clk cycles.
module sio_read_engine
    import sio_rd_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int DUMMY_W = 8,
    parameter int MEM_AW  = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic [1:0]        sio_in,
    input  logic              cmd_go,
    input  logic [1:0]        cmd_kind,
    input  logic [7:0]        mem_rdata,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [1:0]        sio_out,
    output logic [1:0]        sio_oe
);

    logic [1:0] lvl_rise;
    logic [1:0] lvl_fall;
    rd_phase_e  phase;
    logic       dual_in;
    logic       dual_out;
    logic       addr_shift;
    logic       data_load;
    logic       data_shift;

    // Channel 1 is chip select (idles high), channel 0 is SCK
    sio_rd_edge #(
        .N      (2),
        .RST_VAL(2'b10)
    ) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  ({cs_n, sck}),
        .rise (lvl_rise),
        .fall (lvl_fall)
    );

    sio_rd_seq #(
        .ADDR_W (ADDR_W),
        .DUMMY_W(DUMMY_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .cs_rise   (lvl_rise[1]),
        .cs_fall   (lvl_fall[1]),
        .sck_rise  (lvl_rise[0]),
        .sck_fall  (lvl_fall[0]),
        .cmd_go    (cmd_go),
        .cmd_kind  (rd_kind_e'(cmd_kind)),
        .phase     (phase),
        .dual_in   (dual_in),
        .dual_out  (dual_out),
        .addr_shift(addr_shift),
        .data_load (data_load),
        .data_shift(data_shift)
    );

    sio_rd_addr #(
        .ADDR_W(ADDR_W),
        .MEM_AW(MEM_AW)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(addr_shift),
        .dual_in (dual_in),
        .sio_in  (sio_in),
        .step    (data_load),
        .mem_addr(mem_addr)
    );

    sio_rd_tx u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .load   (data_load),
        .shift  (data_shift),
        .dual   (dual_out),
        .rdata  (mem_rdata),
        .sio_out(sio_out),
        .sio_oe (sio_oe)
    );

endmodule

// File: rtl/sio_read_engine_chk.sv
`timescale 1ns/1ps
// Property checker for the read engine, bound to its top level.
module sio_read_engine_chk
    import sio_rd_pkg::*;
#(
    parameter int MEM_AW = 23
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sck,
    input logic              cs_n,
    input logic [1:0]        sio_out,
    input logic [1:0]        sio_oe,
    input logic [MEM_AW-1:0] mem_addr,
    input logic              data_load,
    input rd_phase_e         phase
);

    assert_release_on_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (sio_oe == 2'b00));

    assert_oe_only_in_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_DATA) |-> (sio_oe == 2'b00));

    assert_oe_rises_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sio_oe[1]) |-> (!$past(sck) && $past(sck, 2)));

    assert_dual_uses_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sio_oe[0] |-> sio_oe[1]);

    assert_pointer_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        data_load |=> (mem_addr == MEM_AW'($past(mem_addr) + 1'b1)));

    assert_out_moves_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sio_out) |-> ($past(cs_n) || (!$past(sck) && $past(sck, 2))));

endmodule

bind sio_read_engine sio_read_engine_chk #(.MEM_AW(MEM_AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (sck),
    .cs_n     (cs_n),
    .sio_out  (sio_out),
    .sio_oe   (sio_oe),
    .mem_addr (mem_addr),
    .data_load(data_load),
    .phase    (phase)
);

// File: tb/sio_read_engine_bench.sv
`timescale 1ns/1ps
module sio_read_engine_bench;

    localparam int MEM_AW = 12;
    localparam int DEPTH  = 1 << MEM_AW;
    localparam int WDOG   = 150000;

    // {kind[1:0], spi_mode3, nbytes[4:0], addr[23:0]}
    localparam logic [31:0] VEC [0:7] = '{
        {2'd0, 1'b0, 5'd3, 24'h000010},
        {2'd1, 1'b1, 5'd3, 24'h0001F0},
        {2'd2, 1'b0, 5'd4, 24'h000A5C},
        {2'd3, 1'b1, 5'd4, 24'h0003C7},
        {2'd0, 1'b1, 5'd3, 24'hFFFFFE},
        {2'd3, 1'b0, 5'd3, 24'h7F0FFF},
        {2'd2, 1'b1, 5'd2, 24'hABCFFF},
        {2'd1, 1'b0, 5'd5, 24'h123FFD}
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              sck;
    logic              cs_n;
    logic [1:0]        sio_in;
    logic              cmd_go;
    logic [1:0]        cmd_kind;
    logic [7:0]        mem_rdata;
    logic [MEM_AW-1:0] mem_addr;
    logic [1:0]        sio_out;
    logic [1:0]        sio_oe;

    logic [7:0] mem [DEPTH];
    int  tests = 0;
    int  fails = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    sio_read_engine #(
        .ADDR_W (24),
        .DUMMY_W(8),
        .MEM_AW (MEM_AW)
    ) u_sio_read_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .cs_n     (cs_n),
        .sio_in   (sio_in),
        .cmd_go   (cmd_go),
        .cmd_kind (cmd_kind),
        .mem_rdata(mem_rdata),
        .mem_addr (mem_addr),
        .sio_out  (sio_out),
        .sio_oe   (sio_oe)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp,
                         input string req, input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string kind_tag(input logic [1:0] k);
        case (k)
            2'd0:    return "R2";
            2'd1:    return "R3";
            2'd2:    return "R4";
            default: return "R5";
        endcase
    endfunction

    // One SCK period: rise with data set, then fall
    task automatic tick(input logic [1:0] d);
        @(negedge clk);
        sio_in = d;
        sck    = 1'b1;
        repeat (3) @(negedge clk);
        sck = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic start_cmd(input logic m3, input logic [1:0] kind);
        logic [7:0] op;
        case (kind)
            2'd0:    op = 8'h03;
            2'd1:    op = 8'h0B;
            2'd2:    op = 8'h3B;
            default: op = 8'hBB;
        endcase
        @(negedge clk);
        cs_n = 1'b1;
        sck  = m3;
        repeat (2) @(negedge clk);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        if (m3) begin
            sck = 1'b0;
            repeat (3) @(negedge clk);
        end
        for (int k = 0; k < 8; k++) tick({1'b0, op[7-k]});
        @(negedge clk);
        cmd_go   = 1'b1;
        cmd_kind = kind;
        @(negedge clk);
        cmd_go = 1'b0;
    endtask

    task automatic send_addr(input logic [1:0] kind, input logic [23:0] a, input int nclk);
        if (kind == 2'd3) begin
            for (int k = 0; k < nclk; k++) begin
                if (k == 11) check({6'd0, sio_oe}, 8'h00, "R7", "oe in address");
                tick({a[23-2*k], a[22-2*k]});
            end
        end else begin
            for (int k = 0; k < nclk; k++) begin
                if (k == 23) check({6'd0, sio_oe}, 8'h00, "R7", "oe in address");
                tick({1'b1, a[23-k]});
            end
        end
    endtask

    task automatic send_dummy(input logic [1:0] kind);
        int n;
        n = (kind == 2'd0) ? 0 : (kind == 2'd3) ? 4 : 8;
        for (int k = 0; k < n; k++) tick(2'(k) ^ 2'b10);
    endtask

    task automatic read_bytes(input logic [1:0] kind, input logic [23:0] a, input int nb);
        logic dual;
        logic [7:0] b;
        int idx;
        dual = kind[1];
        check({6'd0, sio_oe}, dual ? 8'h03 : 8'h02, "R7", "oe at first data");
        for (int n = 0; n < nb; n++) begin
            b = '0;
            for (int j = 0; j < (dual ? 4 : 8); j++) begin
                if (dual) b = {b[5:0], sio_out};
                else      b = {b[6:0], sio_out[1]};
                tick(2'b00);
            end
            idx = int'(a[MEM_AW-1:0]) + n;
            check(b, mem[idx % DEPTH], (idx >= DEPTH) ? "R6" : kind_tag(kind), "data byte");
        end
    endtask

    task automatic end_cmd(input string req);
        @(negedge clk);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
        check({4'd0, sio_oe, sio_out}, 8'h00, req, "pins after deselect");
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [1:0]  kind;
        logic        m3;
        logic [4:0]  nb;
        logic [23:0] a;
        logic [1:0]  v0;

        for (int i = 0; i < DEPTH; i++) mem[i] = 8'(i * 29 + (i >> 5) + 3);
        rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; sio_in = 2'b00;
        cmd_go = 1'b0; cmd_kind = 2'd0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({4'd0, sio_oe, sio_out}, 8'h00, "R1", "pins after reset");

        // Vector table walk: every kind, both SPI modes, wrap cases
        for (int v = 0; v < 8; v++) begin
            {kind, m3, nb, a} = VEC[v];
            start_cmd(m3, kind);
            send_addr(kind, a, (kind == 2'd3) ? 12 : 24);
            send_dummy(kind);
            read_bytes(kind, a, int'(nb));
            end_cmd("R8");
        end

        // R9: abort during the address, then a mode 3 command must align
        start_cmd(1'b0, 2'd3);
        send_addr(2'd3, 24'h0A5000, 5);
        end_cmd("R8");
        start_cmd(1'b1, 2'd3);
        send_addr(2'd3, 24'h000ABC, 12);
        send_dummy(2'd3);
        begin
            logic [7:0] b;
            for (int n = 0; n < 2; n++) begin
                b = '0;
                for (int j = 0; j < 4; j++) begin
                    b = {b[5:0], sio_out};
                    tick(2'b00);
                end
                check(b, mem[12'hABC + n], "R9", "byte after aborted command");
            end
        end
        end_cmd("R8");

        // R10: output holds while SCK is high, moves after the fall
        start_cmd(1'b0, 2'd0);
        send_addr(2'd0, 24'h000040, 24);
        v0 = sio_out;
        check({7'd0, v0[1]}, {7'd0, mem[12'h040][7]}, "R10", "first bit");
        @(negedge clk);
        sck = 1'b1;
        repeat (3) @(negedge clk);
        check({6'd0, sio_out}, {6'd0, v0}, "R10", "hold while SCK high");
        sck = 1'b0;
        repeat (3) @(negedge clk);
        check({7'd0, sio_out[1]}, {7'd0, mem[12'h040][6]}, "R10", "second bit");
        // R8: abort in the middle of a data byte
        tick(2'b00);
        tick(2'b00);
        end_cmd("R8");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule